// File: doc/BRIEF.md
# Colour Lookup Table Register File

This block is the colour map of a display controller. It stores 256 main colour entries and 4 overlay colour entries used for a hardware cursor, each entry an 8-bit red, green and blue triple. Software reaches the table through a 32-bit memory-mapped slave port with three live word offsets. It writes the entry number to the index offset. It then makes successive accesses at a data offset, and each access moves one colour component along in the order red, green, blue. After blue the entry number moves on by one, so a whole table can be loaded with one index write followed by a stream of data writes.

The main data offset (4) addresses main entries. The overlay data offset (12) addresses overlay entry 256 + (index mod 4) with the same component sequencing. Reads at a data offset return the current component and advance the sequencer in the same way a write does. A separate combinational lookup port lets the pixel pipeline fetch any of the 260 entries as a packed 24-bit colour at any time, including in a cycle in which the bus writes.

Top module: `clut_regfile`

## Requirements
- R1: A full-word write to byte offset 0 loads the entry index from write data bits 31:24 and returns the component phase to red, whatever the phase was before.
- R2: A full-word write to byte offset 4 stores write data bits 31:24 into the current component of main entry `index`. The phase then advances red, green, blue and back to red.
- R3: A full-word write to byte offset 12 stores into overlay entry 256 + (index mod 4) with the same phase sequence and the same index step after blue. Main entries are left untouched.
- R4: When a blue-phase access completes, the index increments by one and wraps from 255 to 0.
- R5: A full-word read at offset 4 (main) or 12 (overlay) returns the current component in `bus_rdata` bits 31:24, with bits 23:0 zero, on the cycle after the request. It advances phase and index exactly as a write does.
- R6: After reset, every entry is black (0x000000) except main entry 255 and overlay entries 256 and 258, which are white (0xFFFFFF). The index is 0 and the phase is red.
- R7: Accesses whose byte enables are not all ones, writes to offset 8 and reads at offsets 0 or 8 change no entry, no index and no phase. Such reads, and all idle cycles, give `bus_rdata` of zero.
- R8: `lut_rgb` returns entry `lut_idx` combinationally, packed red in 23:16, green in 15:8 and blue in 7:0. Indices 256 to 259 select the overlay entries, indices 260 and above return zero, and a bus write becomes visible on the port right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_be | input | 4 | Byte enables, must be 4'hF to be accepted |
| bus_wdata | input | 32 | Write data, component in bits 31:24 |
| bus_rdata | output | 32 | Registered read data, component in bits 31:24 |
| lut_idx | input | 9 | Pixel lookup entry number |
| lut_rgb | output | 24 | Packed colour of entry `lut_idx` |

## Verification
The bench goes after the index wrap from 255 to 0: a design that carried into a ninth bit or saturated would put the fourth write onto entry 256 or back onto 255 instead of entry 0. It reloads the index part-way through a triple, which catches a design that keeps its old phase and lands a red value in green. It drives overlay writes with an index of 6, so a design that ignored the modulo-4 folding or let overlay data leak into the main table shows a wrong colour at 258 or at main entry 6. Partial-enable and dead-offset accesses are each followed by a normal write whose landing place on the lookup port shows whether phase or index moved.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  // Extract one component of a packed colour; red is the top byte.
  function automatic logic [7:0] lane_of(input logic [23:0] rgb, input logic [1:0] lane);
    case (lane)
      2'd0:    lane_of = rgb[23:16];
      2'd1:    lane_of = rgb[15:8];
      default: lane_of = rgb[7:0];
    endcase
  endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_t           phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  AST_LOAD_IDX: assert property (@(posedge clk) disable iff (rst)
    load |=> (idx == $past(load_val)) && (phase == PH_RED)); // R1

  AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && phase == PH_BLU) |=> (idx == $past(idx) + 1'b1) && (phase == PH_RED)); // R4

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(idx) && $stable(phase)); // R7

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  parameter int ENT_W  = $clog2(MAIN_N + OVL_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [1:0]       wr_lane,
  input  logic [7:0]       wr_byte,
  input  logic [ENT_W-1:0] rd_ent,
  input  logic [1:0]       rd_lane,
  output logic [7:0]       rd_byte,
  input  logic [ENT_W-1:0] lut_ent,
  output logic [23:0]      lut_rgb
);

  localparam int TOTAL = MAIN_N + OVL_N;

  logic [23:0] ent [TOTAL];

  function automatic logic [23:0] reset_colour(input int n);
    if (n == MAIN_N - 1 || n == MAIN_N || n == MAIN_N + 2)
      reset_colour = 24'hFF_FFFF;
    else
      reset_colour = 24'h00_0000;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < TOTAL; n++) ent[n] <= reset_colour(n);
    end else if (wr_en && int'(wr_ent) < TOTAL) begin
      case (wr_lane)
        2'd0:    ent[wr_ent][23:16] <= wr_byte;
        2'd1:    ent[wr_ent][15:8]  <= wr_byte;
        default: ent[wr_ent][7:0]   <= wr_byte;
      endcase
    end
  end

  always_comb begin
    rd_byte = (int'(rd_ent) < TOTAL) ? lane_of(ent[rd_ent], rd_lane) : 8'h00;
    lut_rgb = (int'(lut_ent) < TOTAL) ? ent[lut_ent] : 24'h00_0000;
  end

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_ent) < TOTAL) |=> lane_of(ent[$past(wr_ent)], $past(wr_lane)) == $past(wr_byte)); // R2

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(lut_rgb) || !$stable(lut_ent)); // R7

endmodule

// File: rtl/clut_regfile.sv
module clut_regfile
  import clut_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [8:0]        lut_idx,
  output logic [23:0]       lut_rgb
);

  localparam int IDX_W = $clog2(MAIN_N);
  localparam int OVL_W = $clog2(OVL_N);
  localparam int ENT_W = $clog2(MAIN_N + OVL_N);
  localparam logic [ADDR_W-1:0] OFF_IDX  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MAIN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_OVL  = ADDR_W'(12);

  logic             full_acc, idx_load, data_hit, ovl_sel, rd_hit;
  logic [IDX_W-1:0] cur_idx;
  phase_t           cur_phase;
  logic [ENT_W-1:0] tgt_ent;
  logic [7:0]       rd_byte;
  logic [7:0]       in_byte;
  logic             unused_wdata;

  assign full_acc = bus_sel && (bus_be == 4'hF);
  assign idx_load = full_acc && bus_wr && (bus_addr == OFF_IDX);
  assign ovl_sel  = (bus_addr == OFF_OVL);
  assign data_hit = full_acc && ((bus_addr == OFF_MAIN) || ovl_sel);
  assign rd_hit   = data_hit && !bus_wr;
  assign in_byte  = bus_wdata[DATA_W-1 -: 8];
  assign unused_wdata = ^bus_wdata[DATA_W-9:0];

  assign tgt_ent = ovl_sel ? (ENT_W'(MAIN_N) + ENT_W'(cur_idx[OVL_W-1:0])) : ENT_W'(cur_idx);

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (idx_load),
    .load_val (in_byte[7 -: IDX_W]),
    .step     (data_hit),
    .idx      (cur_idx),
    .phase    (cur_phase)
  );

  clut_store #(.MAIN_N(MAIN_N), .OVL_N(OVL_N), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (data_hit && bus_wr),
    .wr_ent  (tgt_ent),
    .wr_lane (cur_phase),
    .wr_byte (in_byte),
    .rd_ent  (tgt_ent),
    .rd_lane (cur_phase),
    .rd_byte (rd_byte),
    .lut_ent (ENT_W'(lut_idx)),
    .lut_rgb (lut_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= {rd_byte, {(DATA_W-8){1'b0}}};
    else bus_rdata <= '0;
  end

  AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-9:0] == '0); // R5

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> bus_rdata == '0); // R7

  AST_OVL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (data_hit && ovl_sel) |-> int'(tgt_ent) >= MAIN_N && int'(tgt_ent) < MAIN_N + OVL_N); // R3

endmodule

// File: tb/clut_regfile_bench.sv
module clut_regfile_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr, bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [8:0]  lut_idx;
  logic [23:0] lut_rgb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  clut_regfile u_clut_regfile (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  // Row: {wr, offset[3:0], data[31:0], check, expected byte[7:0]}
  localparam int NV = 16;
  localparam logic [45:0] TBL [NV] = '{
    {1'b1, 4'h0, 32'h0500_0000, 1'b0, 8'h00},
    {1'b1, 4'h4, 32'h1100_0000, 1'b0, 8'h00},
    {1'b1, 4'h4, 32'h2200_0000, 1'b0, 8'h00},
    {1'b1, 4'h4, 32'h3300_0000, 1'b0, 8'h00},
    {1'b1, 4'h4, 32'h4400_0000, 1'b0, 8'h00},
    {1'b1, 4'h4, 32'h5500_0000, 1'b0, 8'h00},
    {1'b1, 4'h4, 32'h6600_0000, 1'b0, 8'h00},
    {1'b1, 4'h0, 32'h0500_0000, 1'b0, 8'h00},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h11},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h22},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h33},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h44},
    {1'b1, 4'h0, 32'h0500_0000, 1'b0, 8'h00},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h11},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h22},
    {1'b0, 4'h4, 32'h0000_0000, 1'b1, 8'h33}
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] off, input logic [31:0] dat,
                     input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = off; bus_wdata = dat; bus_be = be;
    @(negedge clk);
    rd = bus_rdata;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic lut_chk(input string req, input int e, input logic [23:0] exp);
    @(negedge clk);
    lut_idx = 9'(e);
    #1;
    check32(req, {8'h00, lut_rgb}, {8'h00, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_be = 4'hF; bus_wdata = 0; lut_idx = 0;
    do_reset();

    // Vector table: R1 reload mid-triple, R2 write order, R5 read data shape
    for (int i = 0; i < NV; i++) begin
      acc(TBL[i][45], TBL[i][44:41], TBL[i][40:9], 4'hF, rd);
      if (TBL[i][8]) check32("R5 table read", rd, {TBL[i][7:0], 24'h0});
    end
    lut_chk("R2 entry 5", 5, 24'h112233);
    lut_chk("R2 entry 6", 6, 24'h445566);

    // R6 reset defaults
    do_reset();
    lut_chk("R6 entry 0", 0, 24'h000000);
    lut_chk("R6 entry 5", 5, 24'h000000);
    lut_chk("R6 entry 255", 255, 24'hFFFFFF);
    lut_chk("R6 entry 256", 256, 24'hFFFFFF);
    lut_chk("R6 entry 257", 257, 24'h000000);
    lut_chk("R6 entry 258", 258, 24'hFFFFFF);
    lut_chk("R6 entry 259", 259, 24'h000000);
    lut_chk("R8 out of range", 300, 24'h000000);
    acc(1'b1, 4'h4, 32'hAA00_0000, 4'hF, rd);
    lut_chk("R6 index and phase zero", 0, 24'hAA0000);

    // R4 wrap 255 -> 0
    acc(1'b1, 4'h0, 32'hFF00_0000, 4'hF, rd);
    acc(1'b1, 4'h4, 32'h0100_0000, 4'hF, rd);
    acc(1'b1, 4'h4, 32'h0200_0000, 4'hF, rd);
    acc(1'b1, 4'h4, 32'h0300_0000, 4'hF, rd);
    acc(1'b1, 4'h4, 32'h0900_0000, 4'hF, rd);
    lut_chk("R4 entry 255", 255, 24'h010203);
    lut_chk("R4 wrapped to 0", 0, 24'h090000);
    lut_chk("R4 no spill to 256", 256, 24'hFFFFFF);

    // R3 overlay folding, index 6 -> entry 258
    acc(1'b1, 4'h0, 32'h0600_0000, 4'hF, rd);
    acc(1'b1, 4'hC, 32'h1200_0000, 4'hF, rd);
    acc(1'b1, 4'hC, 32'h3400_0000, 4'hF, rd);
    acc(1'b1, 4'hC, 32'h5600_0000, 4'hF, rd);
    acc(1'b1, 4'hC, 32'h7700_0000, 4'hF, rd);
    lut_chk("R3 overlay 258", 258, 24'h123456);
    lut_chk("R3 main 6 untouched", 6, 24'h000000);
    lut_chk("R3 overlay 259 after step", 259, 24'h770000);
    acc(1'b1, 4'h0, 32'h0700_0000, 4'hF, rd);
    acc(1'b0, 4'hC, 32'h0, 4'hF, rd);
    check32("R5 overlay read", rd, 32'h7700_0000);

    // R7 ignored accesses
    acc(1'b1, 4'h0, 32'h1000_0000, 4'hF, rd);
    acc(1'b1, 4'h4, 32'h9900_0000, 4'h7, rd);
    acc(1'b1, 4'h8, 32'h8800_0000, 4'hF, rd);
    acc(1'b0, 4'h0, 32'h0, 4'hF, rd);
    check32("R7 read offset 0 zero", rd, 32'h0);
    acc(1'b0, 4'h8, 32'h0, 4'hF, rd);
    check32("R7 read offset 8 zero", rd, 32'h0);
    acc(1'b0, 4'h4, 32'h0, 4'h3, rd);
    check32("R7 partial read zero", rd, 32'h0);
    lut_chk("R7 entry 16 untouched", 16, 24'h000000);
    acc(1'b1, 4'h4, 32'h5A00_0000, 4'hF, rd);
    lut_chk("R7 phase still red", 16, 24'h5A0000);
    acc(1'b1, 4'h0, 32'h2000_0000, 4'h8, rd);
    acc(1'b1, 4'h4, 32'h6B00_0000, 4'hF, rd);
    lut_chk("R7 partial index write ignored", 16, 24'h5A6B00);
    check32("R8 idle rdata", bus_rdata, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule